// File: doc/BRIEF.md
# Console CPU Bus Address Decoder

This block sits between a retro console's 8-bit CPU and everything that CPU can address. Each access arrives as a 16-bit address with a read or write strobe, write data and a two-bit access-kind code. In the same cycle the block picks one target from five: a 2 KiB work RAM held inside the block, an eight-register video-processor port, a sprite-DMA trigger, a stubbed audio/I/O window, or the external cartridge port. The selected target's data comes back as read data in that cycle.

Each counted access advances a CPU cycle counter by one. It then produces three video clock-enable pulses on the fast clock. While those pulses are still due, the block raises a busy flag and refuses new counted accesses. The access kind changes the decoding. A dummy read leaves RAM alone and triggers video side effects only for the status and data registers. A DMA-engine read costs no cycle, is served even while busy, and never reaches the video port.

Top module: `cpu_bus_router`

## Requirements
- R1: A live access below 0x2000 reaches the internal 2 KiB RAM at index addr AND 0x07FF, so the RAM repeats every 0x0800. A write stores wdata there, and a normal read returns the stored byte on rd_data in the same cycle.
- R2: 0x2000 to 0x3FFF is the video window, and vid_idx = addr[2:0]. A normal read raises vid_rd and returns vid_rdata only for index 2, 4 or 7. Every other index returns 0x00 with no strobe.
- R3: A write in the video window raises vid_wr, with vid_wdata = wdata, for every index except 2. A write to index 2 raises no strobe.
- R4: A write to exactly 0x4014 raises dma_start for that cycle only, with dma_page = wdata. Other writes to 0x4000 to 0x401F raise no strobe. Reads of 0x4000 to 0x5FFF return 0x00.
- R5: A live access at or above 0x6000 raises cart_rd or cart_wr, with cart_addr = addr. A cartridge read returns cart_rdata.
- R6: Counted accesses are writes of any kind, plus reads of kind 00 (normal), 10 (dummy) or 11 (treated as normal). An accepted counted access raises cycle_count by one at the next edge. vid_ce is then high for exactly three cycles and low in the fourth.
- R7: busy is high while those enables are still due. A counted access that arrives while busy is refused: it raises no strobe, performs no RAM write, returns 0x00 and adds nothing to cycle_count.
- R8: A dummy read (kind 10) returns 0x00 in the RAM range. In the video window it raises vid_rd only for indices 2 and 7. It still reaches the cartridge.
- R9: A DMA-engine read (kind 01) is served even while busy. It does not change cycle_count and produces no vid_ce. It returns RAM and cartridge data as a normal read would, and returns 0x00 with no strobe in the video and audio/I/O windows.
- R10: When rd_en and wr_en are both high, the access is carried out as a write, no read strobe is raised, rd_data is 0x00, and proto_err is high for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (video) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| kind | input | 2 | Access kind: 00 normal, 01 DMA-engine, 10 dummy, 11 as normal |
| rd_data | output | 8 | Read data, same cycle |
| busy | output | 1 | Video enables still due; counted accesses refused |
| proto_err | output | 1 | Both strobes high this cycle |
| vid_ce | output | 1 | Video clock enable |
| cycle_count | output | 32 | CPU cycle counter |
| vid_rd | output | 1 | Video register read strobe |
| vid_wr | output | 1 | Video register write strobe |
| vid_idx | output | 3 | Video register index |
| vid_wdata | output | 8 | Video register write data |
| vid_rdata | input | 8 | Video register read data |
| dma_start | output | 1 | Sprite-DMA start pulse |
| dma_page | output | 8 | Sprite-DMA source page |
| cart_rd | output | 1 | Cartridge read strobe |
| cart_wr | output | 1 | Cartridge write strobe |
| cart_addr | output | 16 | Cartridge address |
| cart_wdata | output | 8 | Cartridge write data |
| cart_rdata | input | 8 | Cartridge read data |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit data, 2 KiB of RAM, three video pulses per access and a 32-bit cycle counter. With three pulses, the whole busy window is four fast cycles. The bench can therefore place a refused write and a DMA-engine read inside that window and still see the enable burst end. With 2 KiB of RAM, the bench can reach mirrors at 0x0800 and 0x1800 and confirm that they alias the same byte.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    typedef enum logic [1:0] {
        KIND_NORMAL = 2'b00,
        KIND_DMA    = 2'b01,
        KIND_DUMMY  = 2'b10,
        KIND_RSVD   = 2'b11
    } acc_kind_e;

    typedef enum logic [2:0] {
        RGN_RAM,
        RGN_VID,
        RGN_IO,
        RGN_OPEN,
        RGN_CART
    } region_e;

    localparam logic [15:0] RAM_END   = 16'h2000;
    localparam logic [15:0] VID_END   = 16'h4000;
    localparam logic [15:0] IO_END    = 16'h4020;
    localparam logic [15:0] CART_BASE = 16'h6000;
    localparam logic [15:0] DMA_TRIG  = 16'h4014;

endpackage

// File: rtl/cbr_region_decode.sv
module cbr_region_decode
    import cbr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic              is_trig
);

    always_comb begin
        if (addr < ADDR_W'(RAM_END)) begin
            region = RGN_RAM;
        end else if (addr < ADDR_W'(VID_END)) begin
            region = RGN_VID;
        end else if (addr < ADDR_W'(IO_END)) begin
            region = RGN_IO;
        end else if (addr < ADDR_W'(CART_BASE)) begin
            region = RGN_OPEN;
        end else begin
            region = RGN_CART;
        end
        is_trig = (addr == ADDR_W'(DMA_TRIG));
    end

endmodule

// File: rtl/cbr_work_ram.sv
module cbr_work_ram #(
    parameter int BYTES  = 2048,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [BYTES];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[idx] <= wdata;
        end
    end

    assign rdata = cells[idx];

endmodule

// File: rtl/cbr_video_pacer.sv
module cbr_video_pacer #(
    parameter int PULSES = 3,
    parameter int CYC_W  = 32,
    localparam int CNT_W = $clog2(PULSES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             vid_ce,
    output logic [CYC_W-1:0] cycle_count
);

    typedef struct packed {
        logic [CNT_W-1:0] left;
        logic [CYC_W-1:0] cycles;
    } pace_t;

    pace_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.left != '0) begin
            st_d.left = st_q.left - CNT_W'(1);
        end
        if (start) begin
            st_d.left   = CNT_W'(PULSES);
            st_d.cycles = st_q.cycles + CYC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = (st_q.left != '0);
    assign vid_ce      = (st_q.left != '0);
    assign cycle_count = st_q.cycles;

endmodule

// File: rtl/cpu_bus_router.sv
module cpu_bus_router
    import cbr_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int RAM_BYTES  = 2048,
    parameter int VID_PULSES = 3,
    parameter int CYC_W      = 32,
    localparam int IDX_W     = $clog2(RAM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        kind,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              proto_err,
    output logic              vid_ce,
    output logic [CYC_W-1:0]  cycle_count,
    output logic              vid_rd,
    output logic              vid_wr,
    output logic [2:0]        vid_idx,
    output logic [DATA_W-1:0] vid_wdata,
    input  logic [DATA_W-1:0] vid_rdata,
    output logic              dma_start,
    output logic [DATA_W-1:0] dma_page,
    output logic              cart_rd,
    output logic              cart_wr,
    output logic [ADDR_W-1:0] cart_addr,
    output logic [DATA_W-1:0] cart_wdata,
    input  logic [DATA_W-1:0] cart_rdata
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              ram_we;
        logic              vrd;
        logic              vwr;
        logic              dstart;
        logic              crd;
        logic              cwr;
    } bus_t;

    region_e           region;
    logic              is_trig;
    logic [DATA_W-1:0] ram_rdata;
    logic              do_wr, do_rd, counted, take, dma_rd, dummy_rd, live;
    bus_t              bus_d;

    cbr_region_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr    (addr),
        .region  (region),
        .is_trig (is_trig)
    );

    // Write wins when both strobes are high (R10).
    assign do_wr    = wr_en;
    assign do_rd    = rd_en & ~wr_en;
    assign dma_rd   = do_rd & (kind == KIND_DMA);
    assign dummy_rd = do_rd & (kind == KIND_DUMMY);
    assign counted  = do_wr | (do_rd & (kind != KIND_DMA));
    assign take     = counted & ~busy;      // R7 refusal while busy
    assign live     = take | dma_rd;        // R9 DMA reads bypass busy

    always_comb begin
        bus_d = '0;
        if (live) begin
            unique case (region)
                RGN_RAM: begin
                    if (do_wr) begin
                        bus_d.ram_we = 1'b1;
                    end else if (!dummy_rd) begin
                        bus_d.rdata = ram_rdata;
                    end
                end
                RGN_VID: begin
                    if (!dma_rd) begin
                        if (do_wr) begin
                            bus_d.vwr = (addr[2:0] != 3'd2);
                        end else if (addr[2:0] == 3'd2 || addr[2:0] == 3'd7 ||
                                     (addr[2:0] == 3'd4 && !dummy_rd)) begin
                            bus_d.vrd   = 1'b1;
                            bus_d.rdata = vid_rdata;
                        end
                    end
                end
                RGN_IO: begin
                    bus_d.dstart = do_wr & is_trig;
                end
                RGN_CART: begin
                    if (do_wr) begin
                        bus_d.cwr = 1'b1;
                    end else begin
                        bus_d.crd   = 1'b1;
                        bus_d.rdata = cart_rdata;
                    end
                end
                default: begin
                    bus_d = '0;
                end
            endcase
        end
    end

    cbr_work_ram #(.BYTES(RAM_BYTES), .DATA_W(DATA_W)) ram_i (
        .clk   (clk),
        .we    (bus_d.ram_we),
        .idx   (addr[IDX_W-1:0]),
        .wdata (wdata),
        .rdata (ram_rdata)
    );

    cbr_video_pacer #(.PULSES(VID_PULSES), .CYC_W(CYC_W)) pace_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (take),
        .busy        (busy),
        .vid_ce      (vid_ce),
        .cycle_count (cycle_count)
    );

    assign rd_data    = bus_d.rdata;
    assign proto_err  = rd_en & wr_en;
    assign vid_rd     = bus_d.vrd;
    assign vid_wr     = bus_d.vwr;
    assign vid_idx    = addr[2:0];
    assign vid_wdata  = wdata;
    assign dma_start  = bus_d.dstart;
    assign dma_page   = wdata;
    assign cart_rd    = bus_d.crd;
    assign cart_wr    = bus_d.cwr;
    assign cart_addr  = addr;
    assign cart_wdata = wdata;

endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
    parameter int ADDR_W     = 16,
    parameter int VID_PULSES = 3,
    parameter int CYC_W      = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic [1:0]        kind,
    input logic              busy,
    input logic              proto_err,
    input logic              vid_ce,
    input logic [CYC_W-1:0]  cycle_count,
    input logic              vid_rd,
    input logic              vid_wr,
    input logic              dma_start,
    input logic              cart_rd,
    input logic              cart_wr
);

    logic counted_req;
    logic [7:0] ce_run;

    assign counted_req = wr_en | (rd_en & (kind != 2'b01));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_run <= '0;
        end else if (vid_ce) begin
            ce_run <= ce_run + 8'd1;
        end else begin
            ce_run <= '0;
        end
    end

    p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vid_rd, vid_wr, dma_start, cart_rd, cart_wr}));

    p_vid_rd_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vid_rd |-> (addr[2:0] == 3'd2 || addr[2:0] == 3'd4 || addr[2:0] == 3'd7));

    p_vid_wr_skip2_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vid_wr |-> (wr_en && addr[2:0] != 3'd2));

    p_dma_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> (wr_en && addr == ADDR_W'(16'h4014)));

    p_ce_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (counted_req && !busy) |=> vid_ce);

    p_cycle_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (counted_req && !busy) |=> (cycle_count == $past(cycle_count) + CYC_W'(1)));

    p_ce_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ce_run <= 8'(VID_PULSES));

    p_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && counted_req) |-> !(vid_rd || vid_wr || dma_start || cart_rd || cart_wr));

    p_refuse_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && counted_req) |=> (cycle_count == $past(cycle_count)));

    p_dummy_vid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && kind == 2'b10 && vid_rd) |-> (addr[2:0] != 3'd4));

    p_dma_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && kind == 2'b01) |-> (!vid_rd && !vid_wr));

    p_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> (proto_err && !vid_rd && !cart_rd));

endmodule

bind cpu_bus_router cbr_checker #(
    .ADDR_W     (ADDR_W),
    .VID_PULSES (VID_PULSES),
    .CYC_W      (CYC_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .kind        (kind),
    .busy        (busy),
    .proto_err   (proto_err),
    .vid_ce      (vid_ce),
    .cycle_count (cycle_count),
    .vid_rd      (vid_rd),
    .vid_wr      (vid_wr),
    .dma_start   (dma_start),
    .cart_rd     (cart_rd),
    .cart_wr     (cart_wr)
);

// File: tb/cpu_bus_router_tb_top.sv
module cpu_bus_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  kind = 2'b00;
    logic [7:0]  rd_data;
    logic        busy, proto_err, vid_ce;
    logic [31:0] cycle_count;
    logic        vid_rd, vid_wr;
    logic [2:0]  vid_idx;
    logic [7:0]  vid_wdata;
    logic [7:0]  vid_rdata = 8'h3A;
    logic        dma_start;
    logic [7:0]  dma_page;
    logic        cart_rd, cart_wr;
    logic [15:0] cart_addr;
    logic [7:0]  cart_wdata;
    logic [7:0]  cart_rdata = 8'hC5;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    cpu_bus_router dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .wr_en(wr_en), .kind(kind), .rd_data(rd_data),
        .busy(busy), .proto_err(proto_err), .vid_ce(vid_ce),
        .cycle_count(cycle_count), .vid_rd(vid_rd), .vid_wr(vid_wr),
        .vid_idx(vid_idx), .vid_wdata(vid_wdata), .vid_rdata(vid_rdata),
        .dma_start(dma_start), .dma_page(dma_page), .cart_rd(cart_rd),
        .cart_wr(cart_wr), .cart_addr(cart_addr), .cart_wdata(cart_wdata),
        .cart_rdata(cart_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply an access at a falling edge; outputs settle before the next rise.
    task automatic put(input logic r, input logic w, input logic [1:0] k,
                       input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        rd_en = r; wr_en = w; kind = k; addr = a; wdata = d;
        #2;
    endtask

    // Let the access be taken, go idle, and drain the busy window.
    task automatic finish_access;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; kind = 2'b00;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R6 reset busy", busy, 0);
        check("R6 reset vid_ce", vid_ce, 0);
        check("R6 reset cycle_count", cycle_count, 0);
    endtask

    task automatic t_ram;
        put(0, 1, 2'b00, 16'h0123, 8'hA5);
        finish_access();
        put(1, 0, 2'b00, 16'h0923, 8'h00);
        check("R1 mirror 0x0923", rd_data, 8'hA5);
        finish_access();
        put(1, 0, 2'b00, 16'h1923, 8'h00);
        check("R1 mirror 0x1923", rd_data, 8'hA5);
        finish_access();
    endtask

    task automatic t_video_read;
        put(1, 0, 2'b00, 16'h2002, 8'h00);
        check("R2 idx2 strobe", vid_rd, 1);
        check("R2 idx2 data", rd_data, 8'h3A);
        finish_access();
        put(1, 0, 2'b00, 16'h3FFC, 8'h00);
        check("R2 idx4 mirror strobe", vid_rd, 1);
        check("R2 idx4 vid_idx", vid_idx, 3'd4);
        finish_access();
        put(1, 0, 2'b00, 16'h2001, 8'h00);
        check("R2 idx1 no strobe", vid_rd, 0);
        check("R2 idx1 data zero", rd_data, 8'h00);
        finish_access();
    endtask

    task automatic t_video_write;
        put(0, 1, 2'b00, 16'h2005, 8'h5C);
        check("R3 idx5 strobe", vid_wr, 1);
        check("R3 idx5 data", vid_wdata, 8'h5C);
        finish_access();
        put(0, 1, 2'b00, 16'h200A, 8'h11);
        check("R3 idx2 write ignored", vid_wr, 0);
        finish_access();
    endtask

    task automatic t_io;
        put(0, 1, 2'b00, 16'h4014, 8'h07);
        check("R4 dma_start", dma_start, 1);
        check("R4 dma_page", dma_page, 8'h07);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        #2;
        check("R4 dma_start one cycle", dma_start, 0);
        repeat (4) @(negedge clk);
        put(0, 1, 2'b00, 16'h4015, 8'h07);
        check("R4 0x4015 no dma", dma_start, 0);
        check("R4 0x4015 no strobes", {vid_wr, cart_wr}, 0);
        finish_access();
        put(1, 0, 2'b00, 16'h4010, 8'h00);
        check("R4 io read zero", rd_data, 8'h00);
        finish_access();
        put(1, 0, 2'b00, 16'h5000, 8'h00);
        check("R4 open read zero", rd_data, 8'h00);
        check("R4 open no cart", cart_rd, 0);
        finish_access();
    endtask

    task automatic t_cart;
        put(1, 0, 2'b00, 16'h8000, 8'h00);
        check("R5 cart rd", cart_rd, 1);
        check("R5 cart data", rd_data, 8'hC5);
        finish_access();
        put(0, 1, 2'b00, 16'hFFFF, 8'h9E);
        check("R5 cart wr", cart_wr, 1);
        check("R5 cart addr", cart_addr, 16'hFFFF);
        check("R5 cart wdata", cart_wdata, 8'h9E);
        finish_access();
    endtask

    task automatic t_pacing;
        logic [31:0] c0;
        c0 = cycle_count;
        put(1, 0, 2'b00, 16'h0123, 8'h00);
        check("R6 idle before access", vid_ce, 0);
        @(negedge clk);
        rd_en = 1'b0;
        #2;
        check("R6 ce pulse 1", vid_ce, 1);
        check("R6 cycle_count step", cycle_count, c0 + 1);
        check("R7 busy raised", busy, 1);
        // refused write while busy
        @(negedge clk);
        wr_en = 1'b1; addr = 16'h0123; wdata = 8'hEE;
        #2;
        check("R6 ce pulse 2", vid_ce, 1);
        check("R7 refused rd_data", rd_data, 8'h00);
        @(negedge clk);
        wr_en = 1'b0;
        #2;
        check("R6 ce pulse 3", vid_ce, 1);
        check("R7 refused not counted", cycle_count, c0 + 1);
        @(negedge clk);
        #2;
        check("R6 ce ends after three", vid_ce, 0);
        check("R7 busy cleared", busy, 0);
        put(1, 0, 2'b00, 16'h0123, 8'h00);
        check("R7 refused write left RAM", rd_data, 8'hA5);
        finish_access();
    endtask

    task automatic t_dummy;
        logic [31:0] c0;
        c0 = cycle_count;
        put(1, 0, 2'b10, 16'h0123, 8'h00);
        check("R8 dummy RAM zero", rd_data, 8'h00);
        finish_access();
        check("R8 dummy counted", cycle_count, c0 + 1);
        put(1, 0, 2'b10, 16'h2004, 8'h00);
        check("R8 dummy idx4 no strobe", vid_rd, 0);
        finish_access();
        put(1, 0, 2'b10, 16'h2007, 8'h00);
        check("R8 dummy idx7 strobe", vid_rd, 1);
        finish_access();
        put(1, 0, 2'b10, 16'h9000, 8'h00);
        check("R8 dummy cart strobe", cart_rd, 1);
        check("R8 dummy cart data", rd_data, 8'hC5);
        finish_access();
    endtask

    task automatic t_dma;
        logic [31:0] c0;
        c0 = cycle_count;
        put(1, 0, 2'b01, 16'h0123, 8'h00);
        check("R9 dma RAM data", rd_data, 8'hA5);
        @(negedge clk);
        rd_en = 1'b0;
        #2;
        check("R9 dma no ce", vid_ce, 0);
        check("R9 dma no count", cycle_count, c0);
        put(1, 0, 2'b01, 16'h2002, 8'h00);
        check("R9 dma video no strobe", vid_rd, 0);
        check("R9 dma video zero", rd_data, 8'h00);
        put(1, 0, 2'b01, 16'h4016, 8'h00);
        check("R9 dma io zero", rd_data, 8'h00);
        put(1, 0, 2'b01, 16'h8000, 8'h00);
        check("R9 dma cart", {7'd0, cart_rd, rd_data}, {7'd0, 1'b1, 8'hC5});
        // DMA read served while busy
        put(0, 1, 2'b00, 16'h0200, 8'h44);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; kind = 2'b01; addr = 16'h0123;
        #2;
        check("R9 dma while busy flag", busy, 1);
        check("R9 dma while busy data", rd_data, 8'hA5);
        finish_access();
    endtask

    task automatic t_proto;
        put(1, 1, 2'b00, 16'h0200, 8'h5A);
        check("R10 proto_err", proto_err, 1);
        check("R10 read suppressed", rd_data, 8'h00);
        finish_access();
        check("R10 proto_err clear", proto_err, 0);
        put(1, 0, 2'b00, 16'h0200, 8'h00);
        check("R10 write carried out", rd_data, 8'h5A);
        finish_access();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        t_reset();
        t_ram();
        t_video_read();
        t_video_write();
        t_io();
        t_cart();
        t_pacing();
        t_dummy();
        t_dma();
        t_proto();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule